// File: doc/BRIEF.md
# Horizontal microcode decode stage

This block is the middle stage of a three-stage fetch, decode and execute pipeline in which every bit of a very wide horizontal microword directly steers hardware in the execute stage. It takes one 216-bit microword per cycle from the fetch register and does only three things to it. It widens the 16-bit immediate constants carried by two of the function-unit fields to 32 bits, with sign or zero extension chosen by a bit in each field. It blanks every function-unit field to a NOP while the memory system is being reconfigured. It derives one clock enable per function unit from that unit's activity bit. The result is captured in a single output register that feeds the function units, the loop unit and the address generators in the same cycle.

The block reads no registers and checks no dependences. The microword holds four function-unit fields of 40 bits each, unit k at bits 40k+39 down to 40k, followed by a 56-bit sequencing field at bits 215 to 160 for the loop unit and the address generators. Within a function-unit field, bit 39 marks the unit active and bit 38 selects sign extension (1) or zero extension (0). In units 0 and 1, bits 15 to 0 hold the immediate.

Top module: `udec_top`

## Requirements
- R1: While reset is high at a clock edge, every output register clears: outValid low, outClkEn all zero, outFu, outImm and outSeq all zero.
- R2: Each output is registered once: the values presented at one rising edge appear on the outputs just after that edge, and outValid equals inValid of that edge.
- R3: For an immediate-bearing unit (0 or 1) whose bit 38 is 1, the 32-bit outImm slice of that unit (unit k at bits 32k+31 to 32k) equals its bits 15 to 0 with bit 15 copied into the upper 16 bits.
- R4: For an immediate-bearing unit whose bit 38 is 0, its outImm slice equals bits 15 to 0 with the upper 16 bits zero.
- R5: When reconfigBusy is high at the edge, all four function-unit fields of outFu, both outImm slices and all of outClkEn are zero for that word, whatever the fields held.
- R6: With inValid high and reconfigBusy low, bit k of outClkEn equals bit 39 of unit k's field.
- R7: With inValid high, outSeq equals bits 215 to 160 of the microword, whether or not reconfigBusy is high.
- R8: With inValid high and reconfigBusy low, each 40-bit function-unit field passes to outFu unchanged.
- R9: When inValid is low at the edge, outValid is low and outFu, outImm, outClkEn and outSeq are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Microword from fetch is valid |
| inWord | input | 216 | Microword from the fetch register |
| reconfigBusy | input | 1 | Memory reconfiguration in progress; forces NOPs |
| outValid | output | 1 | Decoded word valid |
| outFu | output | 160 | Four function-unit control fields, NOP-substituted |
| outImm | output | 64 | Two extended 32-bit immediates, unit 0 in the low half |
| outClkEn | output | 4 | Per-unit clock enables |
| outSeq | output | 56 | Loop-unit and address-generator field |

## Verification
Every result of this block is due exactly one rising edge after the microword, the valid flag and the busy flag are presented: the extension, the NOP forcing and the clock enables all settle before the single output register. The bench drives each stimulus at a falling edge, lets one rising edge pass and compares all outputs at the next falling edge, before the following word is applied, so each comparison refers to exactly one input word. The checker properties use a one-cycle implication for the same reason.

// File: rtl/udec_pkg.sv
package udec_pkg;
  localparam int NUM_FU    = 4;
  localparam int FU_W      = 40;
  localparam int NUM_IMM   = 2;
  localparam int IMM_IN_W  = 16;
  localparam int IMM_OUT_W = 32;
  localparam int SEQ_W     = 56;
  localparam int WORD_W    = NUM_FU * FU_W + SEQ_W;
  localparam int ACT_BIT   = FU_W - 1;
  localparam int SX_BIT    = FU_W - 2;

  typedef struct packed {
    logic              capture;
    logic              nopAll;
    logic [NUM_FU-1:0] unitEn;
  } dec_strobe_t;
endpackage

// File: rtl/udec_ctrl.sv
module udec_ctrl
  import udec_pkg::*;
#(
  parameter int NFU = NUM_FU
) (
  input  logic           inValid,
  input  logic           reconfigBusy,
  input  logic [NFU-1:0] actBits,
  output dec_strobe_t    strobe
);
  logic blank;

  always_comb begin
    blank          = reconfigBusy | ~inValid;
    strobe.capture = inValid;
    strobe.nopAll  = blank;
    strobe.unitEn  = actBits & {NFU{~blank}};
  end
endmodule

// File: rtl/udec_dp.sv
module udec_dp
  import udec_pkg::*;
#(
  parameter int NFU   = NUM_FU,
  parameter int FW    = FU_W,
  parameter int NIMM  = NUM_IMM,
  parameter int IIN   = IMM_IN_W,
  parameter int IOUT  = IMM_OUT_W,
  parameter int SW    = SEQ_W
) (
  input  logic               clk,
  input  logic               rst,
  input  dec_strobe_t        strobe,
  input  logic [NFU*FW+SW-1:0] inWord,
  output logic               outValid,
  output logic [NFU*FW-1:0]  outFu,
  output logic [NIMM*IOUT-1:0] outImm,
  output logic [NFU-1:0]     outClkEn,
  output logic [SW-1:0]      outSeq
);
  localparam int FU_TOTAL = NFU * FW;
  localparam int PAD_W    = IOUT - IIN;
  localparam int SXB      = FW - 2;

  logic [FU_TOTAL-1:0]  fuNext;
  logic [NIMM*IOUT-1:0] immNext;
  logic [SW-1:0]        seqNext;

  for (genvar k = 0; k < NFU; k++) begin : g_fu
    assign fuNext[k*FW +: FW] = strobe.nopAll ? '0 : inWord[k*FW +: FW];
  end

  for (genvar k = 0; k < NIMM; k++) begin : g_imm
    logic [IIN-1:0] raw;
    logic           signSel;
    assign raw     = fuNext[k*FW +: IIN];
    assign signSel = fuNext[k*FW + SXB];
    assign immNext[k*IOUT +: IOUT] = {{PAD_W{signSel & raw[IIN-1]}}, raw};
  end

  assign seqNext = strobe.capture ? inWord[FU_TOTAL +: SW] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outFu    <= '0;
      outImm   <= '0;
      outClkEn <= '0;
      outSeq   <= '0;
    end else begin
      outValid <= strobe.capture;
      outFu    <= fuNext;
      outImm   <= immNext;
      outClkEn <= strobe.unitEn;
      outSeq   <= seqNext;
    end
  end
endmodule

// File: rtl/udec_top.sv
module udec_top
  import udec_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inValid,
  input  logic [WORD_W-1:0]          inWord,
  input  logic                       reconfigBusy,
  output logic                       outValid,
  output logic [NUM_FU*FU_W-1:0]     outFu,
  output logic [NUM_IMM*IMM_OUT_W-1:0] outImm,
  output logic [NUM_FU-1:0]          outClkEn,
  output logic [SEQ_W-1:0]           outSeq
);
  dec_strobe_t       strobe;
  logic [NUM_FU-1:0] actBits;

  for (genvar k = 0; k < NUM_FU; k++) begin : g_act
    assign actBits[k] = inWord[k*FU_W + ACT_BIT];
  end

  udec_ctrl #(.NFU(NUM_FU)) u_ctrl (
    .inValid      (inValid),
    .reconfigBusy (reconfigBusy),
    .actBits      (actBits),
    .strobe       (strobe)
  );

  udec_dp #(
    .NFU(NUM_FU), .FW(FU_W), .NIMM(NUM_IMM),
    .IIN(IMM_IN_W), .IOUT(IMM_OUT_W), .SW(SEQ_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .inWord   (inWord),
    .outValid (outValid),
    .outFu    (outFu),
    .outImm   (outImm),
    .outClkEn (outClkEn),
    .outSeq   (outSeq)
  );
endmodule

// File: rtl/udec_checker.sv
module udec_checker
  import udec_pkg::*;
(
  input logic                       clk,
  input logic                       rst,
  input logic                       inValid,
  input logic [WORD_W-1:0]          inWord,
  input logic                       reconfigBusy,
  input logic                       outValid,
  input logic [NUM_FU*FU_W-1:0]     outFu,
  input logic [NUM_IMM*IMM_OUT_W-1:0] outImm,
  input logic [NUM_FU-1:0]          outClkEn,
  input logic [SEQ_W-1:0]           outSeq
);
  logic [NUM_FU-1:0] outAct;
  for (genvar k = 0; k < NUM_FU; k++) begin : g_oa
    assign outAct[k] = outFu[k*FU_W + ACT_BIT];
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!outValid && outClkEn == '0 && outFu == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (outValid == $past(inValid)));

  a_r3_sign_ext: assert property (@(posedge clk) disable iff (rst)
    (inValid && !reconfigBusy && inWord[SX_BIT]) |=>
      (outImm[IMM_OUT_W-1:0] ==
       {{(IMM_OUT_W-IMM_IN_W){$past(inWord[IMM_IN_W-1])}}, $past(inWord[IMM_IN_W-1:0])}));

  a_r4_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (inValid && !reconfigBusy && !inWord[SX_BIT]) |=>
      (outImm[IMM_OUT_W-1:IMM_IN_W] == '0));

  a_r5_busy_nop: assert property (@(posedge clk) disable iff (rst)
    reconfigBusy |=> (outFu == '0 && outClkEn == '0 && outImm == '0));

  a_r6_clken_active: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((outClkEn & ~outAct) == '0));

  a_r7_seq_pass: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (outSeq == $past(inWord[WORD_W-1:NUM_FU*FU_W])));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && outClkEn == '0 && outSeq == '0));
endmodule

bind udec_top udec_checker u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
  .reconfigBusy(reconfigBusy), .outValid(outValid), .outFu(outFu),
  .outImm(outImm), .outClkEn(outClkEn), .outSeq(outSeq)
);

// File: tb/udec_top_tb.sv
module udec_top_tb;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [215:0] inWord = '0;
  logic         reconfigBusy = 1'b0;
  logic         outValid;
  logic [159:0] outFu;
  logic [63:0]  outImm;
  logic [3:0]   outClkEn;
  logic [55:0]  outSeq;

  int testCount = 0;
  int failCount = 0;

  always #(PERIOD/2) clk = ~clk;

  udec_top u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .reconfigBusy(reconfigBusy), .outValid(outValid), .outFu(outFu),
    .outImm(outImm), .outClkEn(outClkEn), .outSeq(outSeq)
  );

  function automatic logic [159:0] mFu(logic [215:0] w, logic v, logic b);
    return (v && !b) ? w[159:0] : '0;
  endfunction

  function automatic logic [63:0] mImm(logic [215:0] w, logic v, logic b);
    logic [63:0] r = '0;
    for (int k = 0; k < 2; k++) begin
      logic [15:0] imm = w[k*40 +: 16];
      if (v && !b)
        r[k*32 +: 32] = w[k*40+38] ? {{16{imm[15]}}, imm} : {16'h0000, imm};
    end
    return r;
  endfunction

  function automatic logic [3:0] mEn(logic [215:0] w, logic v, logic b);
    logic [3:0] r = '0;
    for (int k = 0; k < 4; k++) r[k] = v && !b && w[k*40+39];
    return r;
  endfunction

  function automatic logic [55:0] mSeq(logic [215:0] w, logic v);
    return v ? w[215:160] : '0;
  endfunction

  task automatic chk(logic ok, string tag, logic [159:0] act, logic [159:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present one word at a falling edge, compare one rising edge later.
  task automatic step(logic v, logic [215:0] w, logic b, string immTag);
    logic [159:0] eFu;
    logic [63:0]  eImm;
    logic [3:0]   eEn;
    logic [55:0]  eSeq;
    inValid = v; inWord = w; reconfigBusy = b;
    eFu = mFu(w, v, b); eImm = mImm(w, v, b); eEn = mEn(w, v, b); eSeq = mSeq(w, v);
    @(posedge clk);
    @(negedge clk);
    chk(outValid == v, "R2 valid", 160'(outValid), 160'(v));
    chk(outFu == eFu, b ? "R5 fu nop" : (v ? "R8 fu pass" : "R9 fu idle"), outFu, eFu);
    chk(outImm == eImm, immTag, 160'(outImm), 160'(eImm));
    chk(outClkEn == eEn, b ? "R5 clken" : "R6 clken", 160'(outClkEn), 160'(eEn));
    chk(outSeq == eSeq, v ? "R7 seq" : "R9 seq", 160'(outSeq), 160'(eSeq));
  endtask

  function automatic logic [215:0] rndWord();
    logic [215:0] r;
    for (int i = 0; i < 7; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [215:0] mkImmWord(logic [15:0] i0, logic s0, logic [15:0] i1, logic s1);
    logic [215:0] w = '0;
    w[15:0] = i0; w[38] = s0; w[39] = 1'b1;
    w[55:40] = i1; w[78] = s1; w[79] = 1'b1;
    w[215:160] = 56'hA5_5A_C3_3C_0F_F0_99;
    return w;
  endfunction

  task automatic checkReset();
    chk(!outValid && outClkEn == '0, "R1 ctl", {outValid, outClkEn}, '0);
    chk(outFu == '0 && outImm == '0 && outSeq == '0, "R1 data", outFu, '0);
  endtask

  initial begin
    #(PERIOD * 150000);
    failCount++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    checkReset();
    rst = 1'b0;

    // Directed corners for R3 and R4
    step(1'b1, mkImmWord(16'h8000, 1'b1, 16'h8000, 1'b0), 1'b0, "R3/R4 imm neg");
    chk(outImm == 64'h00008000_FFFF8000, "R3 sign 8000", 160'(outImm), 160'(64'h00008000_FFFF8000));
    step(1'b1, mkImmWord(16'h7FFF, 1'b1, 16'hFFFF, 1'b0), 1'b0, "R3/R4 imm pos");
    chk(outImm == 64'h0000FFFF_00007FFF, "R4 zero FFFF", 160'(outImm), 160'(64'h0000FFFF_00007FFF));
    step(1'b1, mkImmWord(16'hFFFF, 1'b0, 16'hFFFF, 1'b1), 1'b0, "R3/R4 imm all ones");
    chk(outImm == 64'hFFFFFFFF_0000FFFF, "R3 sign FFFF", 160'(outImm), 160'(64'hFFFFFFFF_0000FFFF));
    // R5 / R7: busy with every unit active
    step(1'b1, {56'h1122334455_6677, {4{40'hFF_FFFF_FFFF}}}, 1'b1, "R5 imm nop");
    chk(outSeq == 56'h1122334455_6677, "R7 seq under busy", 160'(outSeq), 160'(56'h1122334455_6677));
    // R6: only units 1 and 3 active
    step(1'b1, {56'h0, 40'h80_0000_0001, 40'h00_0000_0002, 40'h80_0000_0003, 40'h00_0000_0004}, 1'b0, "R6 imm");
    chk(outClkEn == 4'b1010, "R6 clken pattern", 160'(outClkEn), 160'(4'b1010));
    // R9: invalid word
    step(1'b0, {216{1'b1}}, 1'b0, "R9 imm idle");
    step(1'b1, {216{1'b1}}, 1'b0, "R8 imm ones");

    for (int n = 0; n < 400; n++) begin
      logic v = ($urandom % 100) < 85;
      logic b = ($urandom % 100) < 25;
      step(v, rndWord(), b, "R3/R4 imm random");
    end

    // R1: reset in mid-stream
    inValid = 1'b1; inWord = {216{1'b1}}; reconfigBusy = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    checkReset();

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule